// File: doc/BRIEF.md
# Retriggerable Attack-Release Slope Generator

This block produces an unsigned 16-bit envelope level that climbs toward full scale and sinks back toward zero. A run latch decides the direction. While it is set, the level rises. While it is clear, the level falls. The level moves only on cycles where the clock-enable `tick` is high, which sets the time base. Each direction has its own step size. Each direction can also be switched to a curved response: the rise speeds up near the top, and the fall slows down near zero.

There are two start inputs, and they behave differently. The gate is level-sensitive. While it is high, the latch stays set, so the level sits at full scale until the gate drops. A gate that arrives during the fall restarts the climb from wherever the level is. The trigger is edge-sensitive. A rising edge launches one complete up-and-down excursion, but only when the level is near zero (the end flag is high). Edges at any other time are ignored. Two status flags are output: one shows the run latch, the other shows that the level is near zero. Routing the end flag back into a start input turns the block into a free-running oscillator.

The controller is a four-state machine:
- ST_IDLE: at zero, latch clear.
- ST_RISE: climbing.
- ST_HOLD: at full scale with the set held.
- ST_FALL: descending.

Its transitions are:
- IDLE→RISE when set is requested.
- RISE→HOLD when full scale is reached while set is still requested.
- RISE→FALL when full scale is reached without set.
- HOLD→FALL when set is released.
- FALL→RISE when set is requested.
- FALL→IDLE when the level reaches zero.

Top module: `slope_gen`

## Requirements
- R1: After reset, level_o is 0, rising_o is 0 and end_o is 1.
- R2: The level changes only on a clock edge where tick is high. It adds the rise step while rising_o is 1 and subtracts the fall step while rising_o is 0. The result saturates at 65535 and at 0. With tick low, level_o holds.
- R3: The rise step is rise_rate plus (rise_exp ? level_o>>2 : 0). The fall step is fall_rate plus (fall_exp ? level_o>>2 : 0). Both steps use the level before the update.
- R4: gate_i high at a clock edge makes rising_o 1 after that edge. While gate_i stays high, the level holds at 65535 with rising_o 1. After gate_i goes low, the level falls.
- R5: gate_i going high while the level is falling sets rising_o again. The climb restarts from the current level, not from zero.
- R6: A set request wins over the full-scale reset request. Reaching 65535 with a set request present keeps rising_o at 1.
- R7: A rising edge of trig_i, seen at a clock edge where end_o is 1, sets rising_o for one full excursion. After full scale is reached, the level falls even if trig_i stays high.
- R8: Trigger edges seen while end_o is 0 are ignored. A falling edge of trig_i never starts the slope.
- R9: end_o is 1 exactly when level_o is below 3932 (6% of the 16-bit full scale).
- R10: rising_o equals the run latch. It is 1 while the level is climbing or holding at full scale, and 0 while falling or at rest.
- R11: Connecting end_o to trig_i makes the block cycle repeatedly without further stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for level motion |
| gate_i | input | 1 | Level-sensitive sustaining start |
| trig_i | input | 1 | Edge-sensitive one-shot start |
| rise_rate | input | 16 | Base rise step per tick |
| fall_rate | input | 16 | Base fall step per tick |
| rise_exp | input | 1 | Curved rise enable |
| fall_exp | input | 1 | Curved fall enable |
| level_o | output | 16 | Envelope level |
| rising_o | output | 1 | Run latch state |
| end_o | output | 1 | Level near zero |

## Verification
A start input sampled at a rising edge shows on rising_o right after that same edge. level_o changes right after an edge where tick was high, and it steps in the direction that rising_o had before that edge. end_o follows level_o combinationally within the same cycle. The bench drives inputs on the falling edge and advances its arithmetic model at the rising edge. It compares all three outputs at the following falling edge, so every result is checked exactly one edge after the stimulus that caused it.

// File: rtl/slope_pkg.sv
package slope_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_HOLD = 2'd2,
        ST_FALL = 2'd3
    } slope_st_e;
endpackage

// File: rtl/slope_edge.sv
// One-clock start pulse on a rising trigger edge, accepted only near base.
module slope_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic near_base,
    output logic fire
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    always_comb fire = trig_i && !trig_q && near_base;
endmodule

// File: rtl/slope_step.sv
// Per-tick step: base rate plus optional level-proportional term.
module slope_step #(
    parameter int LVL_W     = 16,
    parameter int EXP_SHIFT = 2
) (
    input  logic [LVL_W-1:0] rate,
    input  logic             curve_en,
    input  logic [LVL_W-1:0] level,
    output logic [LVL_W:0]   step
);
    logic [LVL_W-1:0] curve_term;

    generate
        if (EXP_SHIFT >= LVL_W) begin : g_no_curve
            always_comb curve_term = '0;
        end else begin : g_curve
            always_comb curve_term = curve_en ? (level >> EXP_SHIFT) : '0;
        end
    endgenerate

    always_comb step = {1'b0, rate} + {1'b0, curve_term};
endmodule

// File: rtl/slope_level.sv
// Saturating level register moved on clock-enable ticks.
module slope_level #(
    parameter int LVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [LVL_W:0]   up_step,
    input  logic [LVL_W:0]   dn_step,
    output logic [LVL_W-1:0] level
);
    localparam int SUM_W = LVL_W + 2;
    localparam logic [LVL_W-1:0] TOP = '1;

    logic [SUM_W-1:0] up_sum;
    logic [LVL_W-1:0] up_val;
    logic [LVL_W-1:0] dn_val;

    always_comb begin
        up_sum = {2'b00, level} + {1'b0, up_step};
        up_val = (up_sum > {2'b00, TOP}) ? TOP : up_sum[LVL_W-1:0];
        dn_val = ({1'b0, level} <= dn_step) ? '0 : (level - dn_step[LVL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    level <= '0;
        else if (tick) level <= run ? up_val : dn_val;
    end
endmodule

// File: rtl/slope_fsm.sv
// Run-latch controller: set has priority over the full-scale reset.
module slope_fsm
    import slope_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic at_peak,
    input  logic at_base,
    output logic run
);
    slope_st_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = set_req ? ST_RISE : ST_IDLE;
            ST_RISE: begin
                if (at_peak) state_nx = set_req ? ST_HOLD : ST_FALL;
                else         state_nx = ST_RISE;
            end
            ST_HOLD: state_nx = set_req ? ST_HOLD : ST_FALL;
            ST_FALL: begin
                if (set_req)      state_nx = ST_RISE;
                else if (at_base) state_nx = ST_IDLE;
                else              state_nx = ST_FALL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RISE, ST_HOLD: run = 1'b1;
            default:          run = 1'b0;
        endcase
    end
endmodule

// File: rtl/slope_gen.sv
module slope_gen #(
    parameter int LVL_W     = 16,
    parameter int EXP_SHIFT = 2,
    parameter int END_PCT   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate_i,
    input  logic             trig_i,
    input  logic [LVL_W-1:0] rise_rate,
    input  logic [LVL_W-1:0] fall_rate,
    input  logic             rise_exp,
    input  logic             fall_exp,
    output logic [LVL_W-1:0] level_o,
    output logic             rising_o,
    output logic             end_o
);
    localparam logic [LVL_W-1:0] TOP     = '1;
    localparam logic [LVL_W-1:0] END_LIM = LVL_W'(((64'd1 << LVL_W) * END_PCT) / 100);

    logic             fire;
    logic             set_req;
    logic             run;
    logic [LVL_W:0]   up_step;
    logic [LVL_W:0]   dn_step;
    logic [LVL_W-1:0] level;

    always_comb begin
        end_o    = (level < END_LIM);
        set_req  = gate_i || fire;
        level_o  = level;
        rising_o = run;
    end

    slope_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .near_base (end_o),
        .fire      (fire)
    );

    slope_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .at_peak (level == TOP),
        .at_base (level == '0),
        .run     (run)
    );

    slope_step #(.LVL_W(LVL_W), .EXP_SHIFT(EXP_SHIFT)) u_up (
        .rate     (rise_rate),
        .curve_en (rise_exp),
        .level    (level),
        .step     (up_step)
    );

    slope_step #(.LVL_W(LVL_W), .EXP_SHIFT(EXP_SHIFT)) u_dn (
        .rate     (fall_rate),
        .curve_en (fall_exp),
        .level    (level),
        .step     (dn_step)
    );

    slope_level #(.LVL_W(LVL_W)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run),
        .up_step (up_step),
        .dn_step (dn_step),
        .level   (level)
    );
endmodule

// File: rtl/slope_gen_chk.sv
module slope_gen_chk #(
    parameter int LVL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             gate_i,
    input logic [LVL_W-1:0] level_o,
    input logic             rising_o,
    input logic             end_o
);
    localparam logic [LVL_W-1:0] TOP = '1;

    // R2
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level_o));

    // R2
    rise_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rising_o && tick) |=> (level_o >= $past(level_o)));

    // R2
    fall_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rising_o && tick) |=> (level_o <= $past(level_o)));

    // R4
    gate_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_i |=> rising_o);

    // R8
    trig_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_o && !gate_i && !rising_o) |=> !rising_o);

    // R10
    rise_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rising_o && level_o != TOP) |=> rising_o);
endmodule

bind slope_gen slope_gen_chk #(.LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .gate_i   (gate_i),
    .level_o  (level_o),
    .rising_o (rising_o),
    .end_o    (end_o)
);

// File: tb/slope_gen_bench.sv
`timescale 1ns/1ps
module slope_gen_bench;
    localparam int unsigned TOPV = 65535;
    localparam int unsigned THR  = 3932;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        gate_i = 1'b0;
    logic        trig_i = 1'b0;
    logic [15:0] rise_rate = 16'd4096;
    logic [15:0] fall_rate = 16'd4096;
    logic        rise_exp = 1'b0;
    logic        fall_exp = 1'b0;
    logic [15:0] level_o;
    logic        rising_o;
    logic        end_o;

    int total = 0;
    int bad = 0;
    int unsigned m_lvl = 0;
    bit m_run = 0;
    bit m_tq = 0;
    int starts = 0;

    always #5 clk = ~clk;

    slope_gen u_slope_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate_i(gate_i), .trig_i(trig_i),
        .rise_rate(rise_rate), .fall_rate(fall_rate), .rise_exp(rise_exp),
        .fall_exp(fall_exp), .level_o(level_o), .rising_o(rising_o), .end_o(end_o)
    );

    task automatic chk_val(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: model update at the rising edge, compare at the falling edge
    task automatic cyc(input string tag);
        bit set;
        bit nrun;
        int unsigned s;
        int unsigned nl;
        @(posedge clk);
        set  = gate_i || (trig_i && !m_tq && (m_lvl < THR));
        nrun = set ? 1'b1 : ((m_lvl == TOPV) ? 1'b0 : m_run);
        nl   = m_lvl;
        if (tick) begin
            if (m_run) begin
                s  = int'(rise_rate) + (rise_exp ? (m_lvl >> 2) : 0);
                nl = m_lvl + s;
                if (nl > TOPV) nl = TOPV;
            end else begin
                s  = int'(fall_rate) + (fall_exp ? (m_lvl >> 2) : 0);
                nl = (s >= m_lvl) ? 0 : m_lvl - s;
            end
        end
        if (nrun && !m_run) starts++;
        m_run = nrun;
        m_tq  = trig_i;
        m_lvl = nl;
        @(negedge clk);
        total++;
        if (int'(level_o) != int'(m_lvl) || rising_o != m_run || end_o != (m_lvl < THR)) begin
            bad++;
            $display("FAIL %s: level=%0d/%0d rising=%0d/%0d end=%0d/%0d (actual/expected)",
                     tag, level_o, m_lvl, rising_o, m_run, end_o, (m_lvl < THR));
        end
    endtask

    task automatic run_idle(input string tag, input int cap);
        for (int i = 0; i < cap; i++) begin
            if (m_lvl == 0 && !m_run) break;
            cyc(tag);
        end
    endtask

    task automatic run_n(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        #1500000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_val("R1 level", int'(level_o), 0);
        chk_val("R1 rising", int'(rising_o), 0);
        chk_val("R1 end", int'(end_o), 1);

        // R3 / R9 sweep of rates and curve options, trigger launched
        for (int e = 0; e < 4; e++) begin
            for (int r = 0; r < 4; r++) begin
                rise_exp  = e[0];
                fall_exp  = e[1];
                rise_rate = (r == 0) ? 16'd1000 : (r == 1) ? 16'd4096 : (r == 2) ? 16'd20000 : 16'd65535;
                fall_rate = (r == 3) ? 16'd1000 : 16'd7000 - 16'(r * 1500);
                trig_i = 1'b1;
                cyc("R3 start");
                trig_i = 1'b0;
                run_idle("R3/R9 sweep", 400);
            end
        end

        rise_exp = 1'b0; fall_exp = 1'b0;
        rise_rate = 16'd4096; fall_rate = 16'd3000;

        // R2 tick gating: tick every third cycle
        trig_i = 1'b1;
        for (int i = 0; i < 300; i++) begin
            tick = (i % 3 == 0);
            cyc("R2 tick");
            if (i == 0) trig_i = 1'b0;
        end
        tick = 1'b1;
        run_idle("R2 drain", 400);

        // R4 / R6 gate sustain at full scale
        gate_i = 1'b1;
        run_n("R4 gate", 20);
        run_n("R6 hold", 6);
        chk_val("R6 level held", int'(level_o), int'(TOPV));
        chk_val("R6 rising held", int'(rising_o), 1);
        gate_i = 1'b0;
        run_n("R4 release", 2);
        chk_val("R4 falling", int'(rising_o), 0);

        // R5 gate during fall restarts from current level
        run_n("R5 fall", 6);
        gate_i = 1'b1;
        cyc("R5 regate");
        gate_i = 1'b0;
        chk_val("R5 rising", int'(rising_o), 1);
        chk_val("R5 not from zero", int'(level_o > 16'd20000), 1);
        run_idle("R5 drain", 400);

        // R7 trigger held high still completes a full excursion
        trig_i = 1'b1;
        cyc("R7 start");
        chk_val("R7 rising", int'(rising_o), 1);
        run_idle("R7 held", 400);
        chk_val("R7 back at base", int'(level_o), 0);
        // R8 held trigger gives no restart, falling edge does nothing
        run_n("R8 held", 5);
        chk_val("R8 no restart", int'(rising_o), 0);
        trig_i = 1'b0;
        run_n("R8 fall edge", 5);
        chk_val("R8 falling edge", int'(rising_o), 0);

        // R8 edges during rise/fall ignored; R5 gate during trigger fall
        trig_i = 1'b1;
        cyc("R8 start");
        for (int i = 0; i < 60; i++) begin
            trig_i = (i % 2 == 1);
            cyc("R8 toggle");
        end
        trig_i = 1'b0;
        gate_i = 1'b1;
        cyc("R5 gate in trig fall");
        gate_i = 1'b0;
        run_idle("R5 drain2", 400);

        // R10 / R11 end fed back into trigger
        starts = 0;
        rise_rate = 16'd8000; fall_rate = 16'd8000;
        for (int i = 0; i < 200; i++) begin
            trig_i = end_o;
            cyc("R11 loop");
        end
        chk_val("R11 cycles", int'(starts >= 3), 1);
        trig_i = 1'b0;
        run_idle("R10 drain", 400);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule